// File: doc/BRIEF.md
# Two-Wire Write-Only Register Loader

This block is a receive-only slave on a two-wire clock/data bus. It watches the bus for a start condition, takes in an 8-bit address byte, and answers with an acknowledge when the address belongs to it and the transfer is a write. It then accepts data bytes and acknowledges each one. Every three data bytes form one 24-bit word, and that word is stored in one of four 24-bit control registers. Those registers drive the frequency synthesizer's dividers and modes.

Five bits of the address are a fixed parameter. Two bits come from a static select input, so up to four loaders can share one bus. The bus lines are brought into an oversampling system clock domain through synchronisers and then edge-detected. The block drives only a pull-down enable for the open-drain data line.

Top module: `twl_loader`

## Requirements
- R1: A fall of the data line while the clock line is high is a start condition. It always begins a new address phase, from any state.
- R2: A rise of the data line while the clock line is high is a stop condition. After a stop the block acknowledges nothing, and it ignores clock pulses until the next start.
- R3: The address byte is sent MSB first. It matches when bits [7:3] equal the parameter ADDR_FIXED (default 5'b11000), bits [2:1] equal `addr_sel_i`, and bit 0 (the read/write flag) is 0. A match is acknowledged.
- R4: On an address mismatch, or when bit 0 is 1, no acknowledge is given. All later bytes are then ignored and no register changes until the next start.
- R5: An acknowledge drives `sda_pull_o` high from the clock fall that ends the eighth bit of a byte until the clock fall that ends the ninth (acknowledge) bit. `sda_pull_o` only changes while the clock line is low.
- R6: After an acknowledged address, each data byte is received MSB first and acknowledged.
- R7: Three consecutive data bytes form a 24-bit word, with the first byte most significant. The whole word is written to the register whose index is word bits [1:0]. Only that register changes, and it changes while the clock line is high during the last bit.
- R8: One transfer may carry several groups of three bytes. Each group writes its own register.
- R9: A start or stop in the middle of a group discards the partial word. Byte grouping restarts at zero after every start.
- R10: Reset clears all four registers and releases the data pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| addr_sel_i | input | SEL_W (2) | Static address-select bits, placed at address bits [2:1] |
| sda_pull_o | output | 1 | Pull-down enable for the open-drain data line |
| regs_o | output | NREG*REG_W (96) | Four control registers; register k at bits [24k+23:24k] |

## Verification
The hardest case to reach is an interrupted group. Here the byte counter holds a partial count when a repeated start or a stop arrives. A loader that failed to clear that count would merge the old bytes with the new ones and write a wrong register. The stimulus sends two bytes, then restarts, then sends three bytes. The first new byte is chosen so that a stale count would route a write to a different register index. The bench also changes the select input between transfers and sends a read-flagged address. It clocks a loose byte after a stop, and checks the line level during every acknowledge clock against the expected ack or no-ack.

// File: rtl/twl_pkg.sv
package twl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ADDR     = 3'd1,
        ST_ACK_WAIT = 3'd2,
        ST_ACK_HOLD = 3'd3,
        ST_DATA     = 3'd4,
        ST_IGNORE   = 3'd5
    } twl_state_e;

endpackage

// File: rtl/twl_sync_edge.sv
module twl_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_ff_q, sda_ff_q;
    logic              scl_prev_q, sda_prev_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff_q   <= '1;
            sda_ff_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_ff_q   <= {scl_ff_q[STAGES-2:0], scl_i};
            sda_ff_q   <= {sda_ff_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_s      = scl_ff_q[STAGES-1];
    assign sda_s      = sda_ff_q[STAGES-1];
    assign sda_s_o    = sda_s;
    assign scl_rise_o = scl_s & ~scl_prev_q;
    assign scl_fall_o = ~scl_s & scl_prev_q;
    // data edge while the clock stays high on both samples
    assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/twl_regbank.sv
module twl_regbank #(
    parameter int NREG  = 4,
    parameter int REG_W = 24,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic [REG_W-1:0]      wdata_i,
    output logic [NREG*REG_W-1:0] regs_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
        logic [REG_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     val_q <= '0;
            else if (we_i && idx_i == SLOT) val_q <= wdata_i;
        end

        assign regs_o[g*REG_W +: REG_W] = val_q;
    end
endmodule

// File: rtl/twl_loader.sv
module twl_loader
    import twl_pkg::*;
#(
    parameter int                NREG        = 4,
    parameter int                REG_W       = 24,
    parameter int                SEL_W       = 2,
    parameter logic [6-SEL_W:0]  ADDR_FIXED  = 5'b11000,
    parameter int                SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [SEL_W-1:0]      addr_sel_i,
    output logic                  sda_pull_o,
    output logic [NREG*REG_W-1:0] regs_o
);
    localparam int BYTES = REG_W / 8;
    localparam int IDX_W = $clog2(NREG);
    localparam int GRP_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(BYTES - 1);

    typedef struct packed {
        twl_state_e       st;
        logic [2:0]       bit_cnt;
        logic [7:0]       sh;
        logic [REG_W-1:0] word;
        logic [GRP_W-1:0] grp;
        logic             pull;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic             we;
    logic [REG_W-1:0] wdata;
    logic [7:0]       rx_byte;

    twl_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s_o   (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_ev),
        .stop_o    (stop_ev)
    );

    assign rx_byte = {ctl_q.sh[6:0], sda_s};

    always_comb begin
        ctl_d = ctl_q;
        we    = 1'b0;
        wdata = {ctl_q.word[REG_W-9:0], rx_byte};
        if (stop_ev) begin
            ctl_d.st   = ST_IDLE;
            ctl_d.pull = 1'b0;
        end else if (start_ev) begin
            ctl_d.st      = ST_ADDR;
            ctl_d.bit_cnt = '0;
            ctl_d.grp     = '0;
            ctl_d.pull    = 1'b0;
        end else begin
            case (ctl_q.st)
                ST_ADDR: if (scl_rise) begin
                    ctl_d.sh      = rx_byte;
                    ctl_d.bit_cnt = ctl_q.bit_cnt + 3'd1;
                    if (ctl_q.bit_cnt == 3'd7)
                        ctl_d.st = (rx_byte[7:1] == {ADDR_FIXED, addr_sel_i} && !rx_byte[0])
                                   ? ST_ACK_WAIT : ST_IGNORE;
                end
                ST_DATA: if (scl_rise) begin
                    ctl_d.sh      = rx_byte;
                    ctl_d.bit_cnt = ctl_q.bit_cnt + 3'd1;
                    if (ctl_q.bit_cnt == 3'd7) begin
                        ctl_d.st   = ST_ACK_WAIT;
                        ctl_d.word = wdata;
                        if (ctl_q.grp == GRP_LAST) begin
                            ctl_d.grp = '0;
                            we        = 1'b1;
                        end else begin
                            ctl_d.grp = ctl_q.grp + GRP_W'(1);
                        end
                    end
                end
                ST_ACK_WAIT: if (scl_fall) begin
                    ctl_d.pull = 1'b1;
                    ctl_d.st   = ST_ACK_HOLD;
                end
                ST_ACK_HOLD: if (scl_fall) begin
                    ctl_d.pull    = 1'b0;
                    ctl_d.bit_cnt = '0;
                    ctl_d.st      = ST_DATA;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    twl_regbank #(.NREG(NREG), .REG_W(REG_W)) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (we),
        .idx_i  (wdata[IDX_W-1:0]),
        .wdata_i(wdata),
        .regs_o (regs_o)
    );

    assign sda_pull_o = ctl_q.pull;
endmodule

// File: rtl/twl_loader_chk.sv
module twl_loader_chk #(
    parameter int NREG  = 4,
    parameter int REG_W = 24
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_pull_o,
    input logic [NREG*REG_W-1:0] regs_o
);
    logic [NREG*REG_W-1:0] prev_q;
    logic [NREG-1:0]       chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= regs_o;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_chg
        assign chg[g] = regs_o[g*REG_W +: REG_W] != prev_q[g*REG_W +: REG_W];
    end

    assert_pull_moves_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);

    assert_write_scl_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> scl_i);

    assert_single_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chg));

    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> (regs_o == '0 && !sda_pull_o));
endmodule

bind twl_loader twl_loader_chk #(.NREG(NREG), .REG_W(REG_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_pull_o(sda_pull_o),
    .regs_o    (regs_o)
);

// File: tb/twl_loader_tb_top.sv
`timescale 1ns/1ps
module twl_loader_tb_top;
    localparam int SETTLE = 8;
    localparam logic [4:0] FIXED = 5'b11000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0]  sel = 2'b01;
    logic        sda_pull;
    logic        sda_bus;
    logic [95:0] regs;

    int          checks = 0, fails = 0, since = 0;
    logic        scl_prev = 1'b1, sda_prev = 1'b1, cmp_en = 1'b0;
    logic        exp_pull = 1'b0;
    logic [23:0] exp_regs [4];
    logic [7:0]  dq [$];

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_pull;

    twl_loader dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .addr_sel_i(sel),
        .sda_pull_o(sda_pull),
        .regs_o    (regs)
    );

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference comparison on every clock once the bus has been quiet for SETTLE cycles
    always @(negedge clk) begin
        if (scl_m !== scl_prev || sda_bus !== sda_prev) since = 0;
        else since++;
        scl_prev = scl_m;
        sda_prev = sda_bus;
        if (cmp_en && since >= SETTLE) begin
            chk(sda_pull === exp_pull, "R5 pull", {23'd0, sda_pull}, {23'd0, exp_pull});
            for (int i = 0; i < 4; i++)
                chk(regs[i*24 +: 24] === exp_regs[i], "R7 reg", regs[i*24 +: 24], exp_regs[i]);
        end
    end

    task automatic wc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_start();
        if (scl_m == 1'b0) begin
            sda_m = 1'b1; wc(10);
            scl_m = 1'b1; wc(10);
        end
        sda_m = 1'b0; wc(10);
        scl_m = 1'b0; wc(10);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wc(10);
        scl_m = 1'b1; wc(10);
        sda_m = 1'b1; wc(20);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ack, input bit wr,
                             input logic [23:0] word, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wc(10);
            scl_m = 1'b1;
            if (i == 0 && wr) exp_regs[word[1:0]] = word;
            wc(20);
            if (i == 0) exp_pull = ack;
            scl_m = 1'b0; wc(10);
        end
        sda_m = 1'b1; wc(10);
        scl_m = 1'b1; wc(10);
        chk(sda_bus === !ack, tag, {23'd0, sda_bus}, {23'd0, !ack});
        wc(10);
        exp_pull = 1'b0;
        scl_m = 1'b0; wc(10);
    endtask

    task automatic xfer(input logic [7:0] addr, input bit stop_at_end);
        bit ack;
        int gc = 0;
        logic [23:0] w;
        do_start();
        ack = (addr[7:1] == {FIXED, sel}) && !addr[0];
        send_byte(addr, ack, 1'b0, 24'd0, ack ? "R1/R3 address ack" : "R4 address no-ack");
        for (int k = 0; k < dq.size(); k++) begin
            w = 24'd0;
            if (gc == 2) w = {dq[k-2], dq[k-1], dq[k]};
            send_byte(dq[k], ack, ack && gc == 2, w, ack ? "R6 data ack" : "R4 data ignored");
            gc = (gc + 1) % 3;
        end
        if (stop_at_end) do_stop();
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_regs[i] = 24'd0;
        wc(5);
        chk(regs === 96'd0, "R10 regs after reset", regs[23:0], 24'd0);
        chk(sda_pull === 1'b0, "R10 pull after reset", {23'd0, sda_pull}, 24'd0);
        rst_n = 1'b1;
        wc(5);
        cmp_en = 1'b1;

        // single word to register 1
        dq = '{8'h12, 8'h34, 8'h5D};
        xfer(8'hC2, 1'b1);
        chk(regs[24 +: 24] === 24'h12345D, "R7 single word", regs[24 +: 24], 24'h12345D);

        // four groups in one transfer
        dq = '{8'h7E, 8'h81, 8'h00, 8'hFF, 8'hFF, 8'hFE, 8'h00, 8'h01, 8'h0B, 8'hA5, 8'h5A, 8'h01};
        xfer(8'hC2, 1'b1);
        chk(regs[0 +: 24] === 24'h7E8100, "R8 group reg0", regs[0 +: 24], 24'h7E8100);
        chk(regs[48 +: 24] === 24'hFFFFFE, "R8 group reg2", regs[48 +: 24], 24'hFFFFFE);
        chk(regs[72 +: 24] === 24'h00010B, "R8 group reg3", regs[72 +: 24], 24'h00010B);
        chk(regs[24 +: 24] === 24'hA55A01, "R8 group reg1", regs[24 +: 24], 24'hA55A01);

        // select pin changed: old address no longer matches
        sel = 2'b10;
        dq = '{8'h11, 8'h22, 8'h33};
        xfer(8'hC2, 1'b1);
        chk(regs[72 +: 24] === 24'h00010B, "R4 mismatch no write", regs[72 +: 24], 24'h00010B);

        // read flag set
        xfer(8'hC5, 1'b1);
        chk(regs[72 +: 24] === 24'h00010B, "R4 read flag no write", regs[72 +: 24], 24'h00010B);

        // repeated start in the middle of a group
        dq = '{8'h99, 8'h88};
        xfer(8'hC4, 1'b0);
        dq = '{8'h01, 8'h02, 8'h03};
        xfer(8'hC4, 1'b1);
        chk(regs[72 +: 24] === 24'h010203, "R9 restart discards partial", regs[72 +: 24], 24'h010203);
        chk(regs[24 +: 24] === 24'hA55A01, "R9 no stale merge", regs[24 +: 24], 24'hA55A01);

        // stop in the middle of a group
        dq = '{8'h44, 8'h55};
        xfer(8'hC4, 1'b1);
        dq = '{8'h66, 8'h77, 8'h80};
        xfer(8'hC4, 1'b1);
        chk(regs[0 +: 24] === 24'h667780, "R9 stop discards partial", regs[0 +: 24], 24'h667780);

        // loose byte after a stop, no start
        scl_m = 1'b0; wc(10);
        send_byte(8'hC4, 1'b0, 1'b0, 24'd0, "R2 no ack after stop");
        do_stop();

        // MSB-first check with a single high bit
        sel = 2'b11;
        dq = '{8'h80, 8'h00, 8'h02};
        xfer(8'hC6, 1'b1);
        chk(regs[48 +: 24] === 24'h800002, "R6 msb first", regs[48 +: 24], 24'h800002);

        wc(20);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule